// File: doc/BRIEF.md
# Staged Post-PLL Clock Divider Bank

This block generates one divided clock-enable stream per output from a single fast clock. Each output counts ticks of its source: either the PLL output tick or, for outputs configured as pre-PLL taps, the reference-clock tick. Every `ratio + 1` source ticks it emits a single-cycle pulse. Each divider has a ratio field and an enable bit. With the enable bit clear, the divider passes its source through, which is divide by one.

New settings do not take effect when software writes them. A write only loads a pending copy. A write-one-to-set GO command then starts a transfer and raises a busy flag. During the transfer, each divider finishes its current period, emits its terminal pulse and then holds. Once every divider is holding, all of them load their pending settings in the same cycle, restart their counts together and busy drops. Software polls busy and must not write settings while it is set.

The control bus is a plain write strobe with a combinational read port. Each access completes in one cycle, so there is no valid/ready back-pressure. The pulse outputs are free-running enables that are not flow-controlled.

Top module: `pll_div_bank`

## Requirements
- R1: After reset every divider is enabled with ratio 0, so each pulses on every tick of its source. Every divider register reads 0x8000 and busy reads 0.
- R2: Divider i is at bus address i (0..3). Bit 15 is its enable bit and bits [4:0] are its ratio. A read returns the pending copy.
- R3: An enabled divider with active ratio r emits one pulse every r+1 ticks of its source.
- R4: A divider whose active enable bit is clear pulses on every source tick, whatever its ratio field holds.
- R5: A divider write with any of bits [14:5] set is rejected and leaves the pending copy unchanged.
- R6: Writing 1 to bit 0 at address 4 (GO) sets busy, which is bit 0 at read address 5, from the next cycle. Busy never rises without a GO.
- R7: Writing pending settings without a GO leaves the pulse outputs unchanged.
- R8: While busy is set, a GO write is ignored and divider writes are ignored. Busy stays high until the transfer completes.
- R9: During a transfer each divider emits its terminal pulse and then holds. When all dividers hold, they load their pending settings together and busy clears in that same cycle. No output pulses in the following cycle, and a PLL-sourced divider with new ratio r first pulses r+1 cycles after busy is seen low.
- R10: Divider 3 is a pre-PLL tap and counts `ref_tick`. Dividers 0..2 count `pll_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Write address |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 16 | Combinational read data |
| pll_tick | input | 1 | PLL output tick enable |
| ref_tick | input | 1 | Reference clock tick enable |
| div_pulse | output | 4 | One-cycle divided enable per output |

## Verification
A wrong active ratio or a wrong count shows within one output period as a pulse spacing that differs from the programmed ratio plus one. A broken hold-and-release shows at the first pulse after busy falls, because the delay from busy low to the first pulse no longer equals the new period. A busy flag that is stuck, set early or set again shows on the status read within a cycle or two of the GO write. A mis-staged write shows on the pending readback, or as outputs that change before any GO.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int BUS_AW   = 3;
  localparam int BUS_DW   = 16;
  localparam int EN_POS   = 15;
  localparam int GO_POS   = 0;
  localparam int BUSY_POS = 0;
  localparam logic [BUS_AW-1:0] CMD_ADDR  = 3'd4;
  localparam logic [BUS_AW-1:0] STAT_ADDR = 3'd5;
endpackage

// File: rtl/pdb_regfile.sv
module pdb_regfile
  import pdb_pkg::*;
#(
  parameter int N_DIV   = 4,
  parameter int RATIO_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [BUS_AW-1:0]          addr,
  input  logic [BUS_DW-1:0]          wdata,
  input  logic [BUS_AW-1:0]          raddr,
  input  logic                       busy,
  input  logic                       commit,
  output logic [BUS_DW-1:0]          rdata,
  output logic                       go_req,
  output logic [N_DIV-1:0]           act_en,
  output logic [N_DIV*RATIO_W-1:0]   act_ratio,
  output logic [N_DIV*(RATIO_W+1)-1:0] pend_flat
);
  localparam int HI_BIT = EN_POS - 1;

  logic [N_DIV-1:0]   pend_en;
  logic [RATIO_W-1:0] pend_ratio [N_DIV];
  logic               over_range;

  assign over_range = |wdata[HI_BIT:RATIO_W];
  assign go_req     = wr && (addr == CMD_ADDR) && wdata[GO_POS];

  for (genvar i = 0; i < N_DIV; i++) begin : g_reg
    logic accept;
    assign accept = wr && (addr == BUS_AW'(i)) && !busy && !over_range;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_en[i]    <= 1'b1;
        pend_ratio[i] <= '0;
      end else if (accept) begin
        pend_en[i]    <= wdata[EN_POS];
        pend_ratio[i] <= wdata[RATIO_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_en[i]                        <= 1'b1;
        act_ratio[i*RATIO_W +: RATIO_W]  <= '0;
      end else if (commit) begin
        act_en[i]                        <= pend_en[i];
        act_ratio[i*RATIO_W +: RATIO_W]  <= pend_ratio[i];
      end
    end

    assign pend_flat[i*(RATIO_W+1) +: RATIO_W+1] = {pend_en[i], pend_ratio[i]};
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_DIV; i++) begin
      if (raddr == BUS_AW'(i)) begin
        rdata[EN_POS]        = pend_en[i];
        rdata[RATIO_W-1:0]   = pend_ratio[i];
      end
    end
    if (raddr == STAT_ADDR) rdata[BUSY_POS] = busy;
  end
endmodule

// File: rtl/pdb_go_ctrl.sv
module pdb_go_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic all_parked,
  output logic busy,
  output logic commit
);
  assign commit = busy && all_parked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy <= 1'b0;
    else if (commit)          busy <= 1'b0;
    else if (!busy && go_req) busy <= 1'b1;
  end
endmodule

// File: rtl/pdb_divider.sv
module pdb_divider #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               busy,
  input  logic               commit,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pulse,
  output logic               parked
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] term;
  logic               at_term;
  logic               fire;

  assign term    = en ? ratio : '0;
  assign at_term = (cnt == term);
  assign fire    = tick && at_term && !parked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      parked <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      pulse <= fire && !commit;
      if (commit) begin
        cnt    <= '0;
        parked <= 1'b0;
      end else begin
        if (!parked && tick) cnt <= at_term ? '0 : cnt + 1'b1;
        if (busy && fire)    parked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_div_bank.sv
module pll_div_bank
  import pdb_pkg::*;
#(
  parameter int               N_DIV        = 4,
  parameter int               RATIO_W      = 5,
  parameter logic [N_DIV-1:0] PRE_PLL_MASK = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [BUS_AW-1:0] bus_raddr,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              pll_tick,
  input  logic              ref_tick,
  output logic [N_DIV-1:0]  div_pulse
);
  logic                         busy;
  logic                         commit;
  logic                         go_req;
  logic [N_DIV-1:0]             act_en;
  logic [N_DIV*RATIO_W-1:0]     act_ratio;
  logic [N_DIV*(RATIO_W+1)-1:0] pend_flat;
  logic [N_DIV-1:0]             parked;

  pdb_regfile #(.N_DIV(N_DIV), .RATIO_W(RATIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .raddr(bus_raddr), .busy(busy), .commit(commit), .rdata(bus_rdata),
    .go_req(go_req), .act_en(act_en), .act_ratio(act_ratio), .pend_flat(pend_flat)
  );

  pdb_go_ctrl u_go (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .all_parked(&parked),
    .busy(busy), .commit(commit)
  );

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    logic src_tick;
    if (PRE_PLL_MASK[i]) begin : g_ref
      assign src_tick = ref_tick;
    end else begin : g_pll
      assign src_tick = pll_tick;
    end

    pdb_divider #(.RATIO_W(RATIO_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(src_tick), .busy(busy), .commit(commit),
      .en(act_en[i]), .ratio(act_ratio[i*RATIO_W +: RATIO_W]),
      .pulse(div_pulse[i]), .parked(parked[i])
    );
  end
endmodule

// File: rtl/pll_div_bank_chk.sv
module pll_div_bank_chk
  import pdb_pkg::*;
#(
  parameter int N_DIV   = 4,
  parameter int RATIO_W = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic [BUS_AW-1:0]            bus_addr,
  input logic [BUS_DW-1:0]            bus_wdata,
  input logic                         busy,
  input logic                         commit,
  input logic [N_DIV-1:0]             div_pulse,
  input logic [N_DIV*(RATIO_W+1)-1:0] pend_flat
);
  logic go_w;
  logic div_w;
  assign go_w  = bus_wr && (bus_addr == CMD_ADDR) && bus_wdata[GO_POS];
  assign div_w = bus_wr && (bus_addr < BUS_AW'(N_DIV));

  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_w && !busy) |=> busy); // R6
  AST_NO_SPURIOUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_w) |=> !busy); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy); // R8
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (div_w && busy) |=> $stable(pend_flat)); // R8
  AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_w && (|bus_wdata[EN_POS-1:RATIO_W])) |=> $stable(pend_flat)); // R5
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R9
  AST_QUIET_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (div_pulse == '0)); // R9
endmodule

bind pll_div_bank pll_div_bank_chk #(.N_DIV(N_DIV), .RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .commit(commit),
  .div_pulse(div_pulse), .pend_flat(pend_flat)
);

// File: tb/pll_div_bank_tb_top.sv
module pll_div_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_EVERY  = 3;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [15:0] bus_rdata;
  logic        pll_tick = 1'b1;
  logic        ref_tick = 1'b0;
  logic [3:0]  div_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pll_div_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .pll_tick(pll_tick), .ref_tick(ref_tick), .div_pulse(div_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      ref_tick = (k % REF_EVERY == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int n = 0; n < 2000; n++) begin
      bus_read(3'd5, s);
      if (!s[0]) return;
      @(negedge clk);
    end
  endtask

  task automatic spacing(input int idx, output int gap);
    gap = -1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (div_pulse[idx]) break;
    end
    for (int n = 1; n < 400; n++) begin
      @(negedge clk);
      if (div_pulse[idx]) begin gap = n; return; end
    end
  endtask

  initial begin
    logic [15:0] rd;
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(div_pulse[2:0] == 3'b111, "R1 pulses", div_pulse, 7);
    bus_read(3'd0, rd); chk(rd == 16'h8000, "R1 div0 reg", rd, 16'h8000);
    bus_read(3'd3, rd); chk(rd == 16'h8000, "R1 div3 reg", rd, 16'h8000);
    bus_read(3'd5, rd); chk(rd[0] == 1'b0, "R1 busy", rd[0], 0);
    spacing(3, g); chk(g == REF_EVERY, "R1 R10 ref div reset", g, REF_EVERY);

    // R2 readback, R7 no effect before GO
    bus_write(3'd0, 16'h8003);
    bus_read(3'd0, rd); chk(rd == 16'h8003, "R2 readback", rd, 16'h8003);
    spacing(0, g); chk(g == 1, "R7 staged only", g, 1);

    // R5 rejected write
    bus_write(3'd0, 16'h8040);
    bus_read(3'd0, rd); chk(rd == 16'h8003, "R5 reject", rd, 16'h8003);

    // R6 GO sets busy next cycle
    bus_write(3'd3, 16'h8007);
    bus_write(3'd4, 16'h0001);
    bus_read(3'd5, rd); chk(rd[0] == 1'b1, "R6 busy rise", rd[0], 1);
    wait_idle();
    spacing(3, g); chk(g == 8*REF_EVERY, "R10 ref div ratio", g, 8*REF_EVERY);

    // R8 GO and writes while busy ignored
    bus_write(3'd1, 16'h8002);
    bus_write(3'd4, 16'h0001);
    bus_write(3'd4, 16'h0001);
    bus_write(3'd1, 16'h8009);
    bus_read(3'd1, rd); chk(rd == 16'h8002, "R8 write while busy", rd, 16'h8002);
    bus_read(3'd5, rd); chk(rd[0] == 1'b1, "R8 busy held", rd[0], 1);
    wait_idle();
    repeat (2) @(negedge clk);
    bus_read(3'd5, rd); chk(rd[0] == 1'b0, "R8 extra GO dropped", rd[0], 0);

    // Sweep all ratios on divider 0 with companions
    for (int r = 0; r < 32; r++) begin
      int d;
      bus_write(3'd0, 16'h8000 | 16'(r));
      bus_write(3'd1, 16'h8000 | 16'(31 - r));
      bus_write(3'd2, 16'(r));
      bus_write(3'd3, 16'h8000 | 16'(r % 4));
      bus_write(3'd4, 16'h0001);
      wait_idle();
      d = -1;
      for (int n = 1; n < 100; n++) begin
        @(negedge clk);
        if (div_pulse[0]) begin d = n; break; end
      end
      chk(d == r + 1, "R9 aligned first pulse", d, r + 1);
      spacing(0, g); chk(g == r + 1, "R3 div0 period", g, r + 1);
      spacing(1, g); chk(g == 32 - r, "R3 div1 period", g, 32 - r);
      spacing(2, g); chk(g == 1, "R4 disabled passthrough", g, 1);
      spacing(3, g); chk(g == (r % 4 + 1) * REF_EVERY, "R10 pre-PLL period", g, (r % 4 + 1) * REF_EVERY);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule